// File: doc/BRIEF.md
# Check-Node Running Accumulator Bank

This block holds the per-check-node state of a serial sum-product decoder that processes one bit node per cycle. For every check node it keeps two quantities: the exclusive-OR of all message signs seen so far in the iteration, and the sum of all transformed message magnitudes seen so far. Each cycle the bit-node side presents up to `DEG` updates, one per lane. Each update carries a check index, a sign bit and a transformed magnitude. The block reads the addressed entries, folds in the new values and writes them back, all in the same cycle.

Storage is split into two banks that act as a ping-pong pair. One bank collects the running totals of the current iteration. The other bank holds the finished totals of the previous iteration and serves them on a read port. That read port is addressed by the same lane indices as the updates, so regenerating outgoing messages and accumulating new ones proceed in lock-step.

When the last bit node of an iteration is presented, `iter_end` is raised with it. The updates of that cycle are included in the totals, and the banks then swap roles. The bank that is about to collect is emptied logically through per-entry valid bits, so no clearing pass is needed. A regular code never connects a bit to the same check twice. Two enabled lanes that name the same index are therefore reported as an error, and that cycle's updates are discarded.

Top module: `chk_accum_bank`

## Requirements
- R1: After reset, every entry read through the previous-iteration port returns sign 0 and sum 0, and the first iteration accumulates from sign 0 and sum 0.
- R2: An accepted update sets the entry's sign to the stored sign XOR the lane's sign bit.
- R3: An accepted update sets the entry's sum to the stored sum plus the lane's transformed magnitude.
- R4: Entries not named by any accepted update in a cycle keep their value.
- R5: Up to `DEG` lanes with distinct indices are all applied in the same cycle.
- R6: The sum saturates at the all-ones code of `MSG_W-1` bits (15 for `MSG_W`=5) and never wraps.
- R7: Updates presented together with `iter_end` are included in the finished totals. After that edge, the read port serves those totals, and the new collecting bank starts every entry at sign 0 and sum 0.
- R8: The read port returns, one cycle after an index is presented on lane l, the previous iteration's total for that index in lane l of `prev_sign`/`prev_mag`. Updates in the current iteration do not change what it returns.
- R9: If two enabled lanes carry the same index, `dup_err` is high in that same cycle and none of that cycle's updates is applied.
- R10: A lane whose `upd_en` bit is 0 changes no entry and takes no part in duplicate detection.
- R11: The banks alternate on every `iter_end`, so each iteration's totals depend only on the updates of that iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | DEG | Per-lane update valid |
| upd_idx | input | DEG*IDX_W | Per-lane check index (lane l at bits l*IDX_W upward); also read address |
| upd_sign | input | DEG | Per-lane message sign |
| upd_mag | input | DEG*(MSG_W-1) | Per-lane transformed magnitude |
| iter_end | input | 1 | This cycle carries the last bit node of the iteration |
| prev_sign | output | DEG | Registered previous-iteration sign per lane |
| prev_mag | output | DEG*(MSG_W-1) | Registered previous-iteration sum per lane |
| dup_err | output | 1 | Two enabled lanes share an index this cycle |

## Verification
The bench builds the block with 16 check nodes, three lanes and 5-bit entries. With these values the whole bank can be read back in six cycles, so untouched entries are checked as well as updated ones. The 4-bit sum overflows after two large additions, which makes saturation easy to hit. Three lanes allow both a colliding pair and a disabled lane carrying a colliding index. Several consecutive iterations exercise both bank orientations and show that stale totals from two iterations back never reappear.

// File: rtl/cnab_pkg.sv
package cnab_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_sel_e;
endpackage

// File: rtl/cnab_lane_upd.sv
module cnab_lane_upd #(
  parameter int MAG_W = 4
) (
  input  logic             old_sign,
  input  logic [MAG_W-1:0] old_mag,
  input  logic             in_sign,
  input  logic [MAG_W-1:0] in_mag,
  output logic             new_sign,
  output logic [MAG_W-1:0] new_mag
);
  logic [MAG_W:0] sum_full;

  always_comb begin
    sum_full = {1'b0, old_mag} + {1'b0, in_mag};
    new_sign = old_sign ^ in_sign;
    new_mag  = sum_full[MAG_W] ? {MAG_W{1'b1}} : sum_full[MAG_W-1:0];
  end
endmodule

// File: rtl/cnab_dup_chk.sv
module cnab_dup_chk #(
  parameter int DEG   = 3,
  parameter int IDX_W = 4
) (
  input  logic [DEG-1:0]       lane_en,
  input  logic [DEG*IDX_W-1:0] lane_idx,
  output logic                 dup
);
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < DEG; a++) begin
      for (int b = a + 1; b < DEG; b++) begin
        if (lane_en[a] && lane_en[b] &&
            (lane_idx[a*IDX_W +: IDX_W] == lane_idx[b*IDX_W +: IDX_W]))
          dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cnab_bank.sv
module cnab_bank #(
  parameter int NUM_CHK = 64,
  parameter int DEG     = 3,
  parameter int MSG_W   = 6,
  localparam int IDX_W  = $clog2(NUM_CHK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [DEG-1:0]       wr_en,
  input  logic [DEG*IDX_W-1:0] wr_idx,
  input  logic [DEG*MSG_W-1:0] wr_data,
  input  logic [DEG*IDX_W-1:0] rd_idx,
  output logic [DEG*MSG_W-1:0] rd_data
);
  logic [MSG_W-1:0]   mem_q [NUM_CHK];
  logic [MSG_W-1:0]   mem_d [NUM_CHK];
  logic [NUM_CHK-1:0] vld_q, vld_d, ent_we;

  // next-state: per-entry write decode and valid tracking
  always_comb begin
    vld_d  = clr ? '0 : vld_q;
    ent_we = '0;
    for (int e = 0; e < NUM_CHK; e++) begin
      mem_d[e] = mem_q[e];
      for (int l = 0; l < DEG; l++) begin
        if (wr_en[l] && (int'(wr_idx[l*IDX_W +: IDX_W]) == e)) begin
          mem_d[e]  = wr_data[l*MSG_W +: MSG_W];
          vld_d[e]  = 1'b1;
          ent_we[e] = 1'b1;
        end
      end
    end
  end

  // storage array: enabled, no reset (valid bits gate the contents)
  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_CHK; e++) begin
      if (ent_we[e]) mem_q[e] <= mem_d[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // combinational read: an invalid entry reads as sign 0, sum 0
  always_comb begin
    for (int l = 0; l < DEG; l++) begin
      logic [IDX_W-1:0] ridx;
      ridx = rd_idx[l*IDX_W +: IDX_W];
      if ((int'(ridx) < NUM_CHK) && vld_q[ridx])
        rd_data[l*MSG_W +: MSG_W] = mem_q[ridx];
      else
        rd_data[l*MSG_W +: MSG_W] = '0;
    end
  end

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|wr_en)) |=> (vld_q == '0)); // R7
endmodule

// File: rtl/chk_accum_bank.sv
module chk_accum_bank
  import cnab_pkg::*;
#(
  parameter int NUM_CHK = 64,
  parameter int DEG     = 3,
  parameter int MSG_W   = 6,
  localparam int IDX_W  = $clog2(NUM_CHK),
  localparam int MAG_W  = MSG_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEG-1:0]       upd_en,
  input  logic [DEG*IDX_W-1:0] upd_idx,
  input  logic [DEG-1:0]       upd_sign,
  input  logic [DEG*MAG_W-1:0] upd_mag,
  input  logic                 iter_end,
  output logic [DEG-1:0]       prev_sign,
  output logic [DEG*MAG_W-1:0] prev_mag,
  output logic                 dup_err
);
  bank_sel_e            wr_sel_q, wr_sel_d;
  logic                 dup;
  logic [DEG-1:0]       we, we_a, we_b;
  logic                 clr_a, clr_b;
  logic [DEG*MSG_W-1:0] rd_a, rd_b, cur_rd, prv_rd, wr_data;
  logic [DEG*MSG_W-1:0] prev_q, prev_d;

  cnab_dup_chk #(.DEG(DEG), .IDX_W(IDX_W)) u_dup (
    .lane_en (upd_en),
    .lane_idx(upd_idx),
    .dup     (dup)
  );

  assign dup_err = dup;

  // write enables and bank roles
  always_comb begin
    we       = upd_en & ~{DEG{dup}};
    we_a     = (wr_sel_q == BANK_A) ? we : '0;
    we_b     = (wr_sel_q == BANK_B) ? we : '0;
    clr_a    = iter_end && (wr_sel_q == BANK_B);
    clr_b    = iter_end && (wr_sel_q == BANK_A);
    cur_rd   = (wr_sel_q == BANK_A) ? rd_a : rd_b;
    prv_rd   = (wr_sel_q == BANK_A) ? rd_b : rd_a;
    wr_sel_d = wr_sel_q;
    if (iter_end) wr_sel_d = (wr_sel_q == BANK_A) ? BANK_B : BANK_A;
    prev_d   = prv_rd;
  end

  generate
    for (genvar l = 0; l < DEG; l++) begin : g_lane
      logic             n_sign;
      logic [MAG_W-1:0] n_mag;

      cnab_lane_upd #(.MAG_W(MAG_W)) u_upd (
        .old_sign(cur_rd[l*MSG_W + MAG_W]),
        .old_mag (cur_rd[l*MSG_W +: MAG_W]),
        .in_sign (upd_sign[l]),
        .in_mag  (upd_mag[l*MAG_W +: MAG_W]),
        .new_sign(n_sign),
        .new_mag (n_mag)
      );

      assign wr_data[l*MSG_W +: MSG_W] = {n_sign, n_mag};

      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        we[l] |-> ({1'b0, n_mag} >= {1'b0, cur_rd[l*MSG_W +: MAG_W]})); // R6

      assign prev_sign[l]              = prev_q[l*MSG_W + MAG_W];
      assign prev_mag[l*MAG_W +: MAG_W] = prev_q[l*MSG_W +: MAG_W];
    end
  endgenerate

  cnab_bank #(.NUM_CHK(NUM_CHK), .DEG(DEG), .MSG_W(MSG_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .clr(clr_a), .wr_en(we_a), .wr_idx(upd_idx),
    .wr_data(wr_data), .rd_idx(upd_idx), .rd_data(rd_a)
  );

  cnab_bank #(.NUM_CHK(NUM_CHK), .DEG(DEG), .MSG_W(MSG_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .clr(clr_b), .wr_en(we_b), .wr_idx(upd_idx),
    .wr_data(wr_data), .rd_idx(upd_idx), .rd_data(rd_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel_q <= BANK_A;
      prev_q   <= '0;
    end else begin
      wr_sel_q <= wr_sel_d;
      prev_q   <= prev_d;
    end
  end

  AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|we_a, |we_b})); // R7
  AST_DUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> !(|we_a) && !(|we_b)); // R9
  AST_SWAP_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    iter_end |=> (wr_sel_q != $past(wr_sel_q))); // R11
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((we_a | we_b) & ~upd_en) == '0); // R10
endmodule

// File: tb/chk_accum_bank_bench.sv
`timescale 1ns/1ps
module chk_accum_bank_bench;
  localparam int M  = 16;
  localparam int D  = 3;
  localparam int Q  = 5;
  localparam int IW = 4;
  localparam int MW = Q - 1;
  localparam int MAXM = 15;

  logic          clk, rst_n;
  logic [D-1:0]  upd_en, upd_sign, prev_sign;
  logic [D*IW-1:0] upd_idx;
  logic [D*MW-1:0] upd_mag, prev_mag;
  logic          iter_end, dup_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_s[M], cur_m[M], prv_s[M], prv_m[M];

  chk_accum_bank #(.NUM_CHK(M), .DEG(D), .MSG_W(Q)) u_chk_accum_bank (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
    .upd_sign(upd_sign), .upd_mag(upd_mag), .iter_end(iter_end),
    .prev_sign(prev_sign), .prev_mag(prev_mag), .dup_err(dup_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one update cycle; model applies the same rules independently
  task automatic step(input logic [2:0] en, input int i0, input int i1, input int i2,
                      input logic [2:0] sg, input int m0, input int m1, input int m2,
                      input logic last, input string req);
    int ix[3];
    int mg[3];
    logic exp_dup;
    ix = '{i0, i1, i2};
    mg = '{m0, m1, m2};
    @(negedge clk);
    upd_en   = en;
    upd_idx  = {IW'(i2), IW'(i1), IW'(i0)};
    upd_sign = sg;
    upd_mag  = {MW'(m2), MW'(m1), MW'(m0)};
    iter_end = last;
    exp_dup = 1'b0;
    for (int a = 0; a < 3; a++)
      for (int b = a + 1; b < 3; b++)
        if (en[a] && en[b] && ix[a] == ix[b]) exp_dup = 1'b1;
    #1;
    check({req, " dup_err"}, int'(dup_err), int'(exp_dup));
    if (!exp_dup)
      for (int l = 0; l < 3; l++)
        if (en[l]) begin
          cur_s[ix[l]] = cur_s[ix[l]] ^ int'(sg[l]);
          cur_m[ix[l]] = (cur_m[ix[l]] + mg[l] > MAXM) ? MAXM : cur_m[ix[l]] + mg[l];
        end
    @(posedge clk);
    if (last)
      for (int e = 0; e < M; e++) begin
        prv_s[e] = cur_s[e]; prv_m[e] = cur_m[e];
        cur_s[e] = 0;        cur_m[e] = 0;
      end
    @(negedge clk);
    upd_en = '0; iter_end = 1'b0;
  endtask

  // read three entries through the previous-iteration port
  task automatic read3(input int i0, input int i1, input int i2, input string req);
    int ix[3];
    ix = '{i0, i1, i2};
    @(negedge clk);
    upd_en  = '0;
    iter_end = 1'b0;
    upd_idx = {IW'(i2), IW'(i1), IW'(i0)};
    @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      check($sformatf("%s sign idx %0d", req, ix[l]), int'(prev_sign[l]), prv_s[ix[l]]);
      check($sformatf("%s sum idx %0d", req, ix[l]), int'(prev_mag[l*MW +: MW]), prv_m[ix[l]]);
    end
  endtask

  task automatic read_all(input string req);
    for (int b = 0; b < M; b += 3) read3(b % M, (b + 1) % M, (b + 2) % M, req);
  endtask

  task automatic t_reset;
    check("R1 dup_err after reset", int'(dup_err), 0);
    read3(0, 5, 15, "R1 reset");
  endtask

  task automatic t_accum;
    for (int c = 0; c < 7; c++)
      step(3'b111, (c*5) % M, (c*5 + 3) % M, (c*5 + 9) % M, 3'(c),
           (c*7) % 16, (c*3 + 1) % 4, c % 3, c == 6, "R5 accum");
    read_all("R2 R3 R4 R7 R1 first iteration");
  endtask

  task automatic t_sat;
    step(3'b111, 7, 2, 11, 3'b001, 9, 1, 0, 1'b0, "R6 sat");
    step(3'b111, 7, 3, 12, 3'b101, 9, 2, 6, 1'b0, "R6 sat");
    step(3'b011, 7, 2, 0, 3'b011, 9, 15, 0, 1'b1, "R6 sat");
    read3(7, 2, 3, "R6 saturation");
    read3(11, 12, 0, "R6 R11 fresh start");
  endtask

  task automatic t_dup;
    step(3'b011, 4, 4, 9, 3'b011, 5, 6, 0, 1'b0, "R9 collide");
    step(3'b011, 4, 9, 4, 3'b111, 3, 2, 8, 1'b0, "R10 disabled lane");
    step(3'b111, 1, 6, 1, 3'b111, 2, 2, 2, 1'b1, "R9 collide on last");
    read3(4, 9, 1, "R9 R10 dropped");
    read3(6, 7, 2, "R11 stale gone");
  endtask

  task automatic t_isolate;
    step(3'b111, 3, 4, 5, 3'b010, 1, 2, 3, 1'b0, "R8 upd");
    read3(3, 4, 9, "R8 previous unaffected");
    step(3'b001, 3, 0, 0, 3'b001, 4, 0, 0, 1'b1, "R7 last carries update");
    read3(3, 4, 5, "R7 R8 after swap");
  endtask

  task automatic t_pingpong;
    for (int it = 0; it < 3; it++) begin
      step(3'b111, it, it + 4, it + 8, 3'(it + 3), it + 1, 2*it, 3, 1'b0, "R11 pp");
      step(3'b100, 0, 0, it + 12, 3'b100, 0, 0, it + 5, 1'b1, "R11 pp last");
      read3(it, it + 4, it + 8, "R11 ping-pong");
      read3(it + 12, 15, 10, "R11 ping-pong tail");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before the run completed");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int e = 0; e < M; e++) begin
      cur_s[e] = 0; cur_m[e] = 0; prv_s[e] = 0; prv_m[e] = 0;
    end
    rst_n = 1'b0; upd_en = '0; upd_idx = '0; upd_sign = '0; upd_mag = '0; iter_end = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_accum();
    t_sat();
    t_dup();
    t_isolate();
    t_pingpong();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule